// File: doc/BRIEF.md
# Key-Locked Flash Program/Erase Controller

This controller decides whether a CPU data write lands in ordinary RAM or turns into a flash operation. It sits between a simple CPU write port and a behavioural byte-array model of on-chip flash. Two register writes prepare an operation. The first is a two-byte unlock code written to a key register. The second sets a program-enable bit, and optionally an erase-enable bit, in a control register.

The next data write then does one of two things. If erase is enabled, it erases the whole page that holds the address. Otherwise it programs the single addressed byte. Programming can only clear bits. Each unlock pays for exactly one operation. A key written with the wrong value, or in the wrong order, shuts flash access off until reset.

A busy flag covers a fixed number of cycles after each operation. While it is high the CPU is stalled and every write is dropped. The key state is reported on a status output, and the flash model has a read port so the stored bytes can be observed.

Top module: `flash_prog_ctrl`

## Requirements
- R1: After reset the key state reads 1 (idle), and busy, the lock error flag and both enable bits read 0.
- R2: Writing 0xA5 to the key register (reg_sel=1) in state 1 moves the key state to 2. Writing 0xF1 in state 2 then moves it to 3 (unlocked).
- R3: Any other key value in state 1 or 2, or any key write in state 3, moves the key state to 0 and raises err_lock. State 0 is left only by reset. While in state 0, data writes go to RAM (ram_wr=1) and flash is unchanged.
- R4: With program-enable set (control bit 0, reg_sel=0) and erase-enable clear (control bit 1), a data write in state 3 stores old AND data at the addressed byte. Neighbouring bytes are unchanged.
- R5: With both enable bits set, a data write in state 3 to any address sets all 1024 bytes of that page to 0xFF. The other page is unchanged.
- R6: A flash operation returns the key state to 1. A further data write without a fresh unlock goes to RAM and leaves flash unchanged.
- R7: A data write while program-enable is clear raises ram_wr, leaves flash unchanged and keeps the key state at 3.
- R8: A data write flagged as an 8-bit-address write (mem_short=1) whose address is above 0x00FF is ignored. Flash is unchanged, ram_wr stays 0 and the key state stays 3. A short write at or below 0x00FF behaves normally.
- R9: busy is high for exactly 4 cycles after a program and 32 cycles after an erase. Key, control and data writes made while busy is high are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 = control register, 1 = key register |
| reg_wdata | input | 8 | Register write data |
| mem_wr | input | 1 | Data write strobe |
| mem_short | input | 1 | Data write uses the 8-bit address form |
| mem_addr | input | 11 | Data write byte address |
| mem_wdata | input | 8 | Data write byte |
| rd_addr | input | 11 | Flash model read address |
| rd_data | output | 8 | Flash model read data |
| ram_wr | output | 1 | Data write routed to RAM this cycle |
| busy | output | 1 | Flash operation in progress, CPU stalled |
| key_state | output | 2 | 0 locked-out, 1 idle, 2 first key seen, 3 unlocked |
| err_lock | output | 1 | Bad key sequence seen since reset |
| ctrl_wen | output | 1 | Program-enable control bit |
| ctrl_een | output | 1 | Erase-enable control bit |

## Verification
Byte programming is driven both by directed patterns and by seeded random address/data pairs. Re-programming one byte with overlapping data separates an AND merge from a plain overwrite. Comparing neighbours and page-boundary bytes (0x3FF against 0x400) separates a single-byte or single-page effect from a spill into adjacent storage. Key sequences cover the good order, a bad first value, a repeated first key and an extra key after unlock, which tells a correct sticky lock from a resettable or ignored one. Writes made without a fresh unlock, with program-enable clear, via a short address above 0xFF, or during busy each check a distinct path by which flash must stay untouched.

// File: rtl/flash_ctl_pkg.sv
// Package: shared types and constants for the flash program/erase controller.
// Assumes the key codes are fixed; sizes are given as parameters on the modules.
package flash_ctl_pkg;
    typedef enum logic [1:0] {
        KS_LOCKED = 2'd0,
        KS_IDLE   = 2'd1,
        KS_FIRST  = 2'd2,
        KS_OPEN   = 2'd3
    } key_state_t;

    localparam logic [7:0] KEY_CODE_A = 8'hA5;
    localparam logic [7:0] KEY_CODE_B = 8'hF1;
    localparam logic [7:0] ERASED_BYTE = 8'hFF;

    localparam logic SEL_CTRL = 1'b0;
    localparam logic SEL_KEY  = 1'b1;
endpackage

// File: rtl/flash_key_fsm.sv
// Module: unlock-key state machine.
// Walks idle -> first key -> unlocked on the two codes in order and drops
// into a sticky locked-out state on any other key write. A flash operation
// (consume) returns an unlocked machine to idle.
// Assumes: consume is raised only while the state is unlocked and never in
// the same cycle as key_wr.
module flash_key_fsm
    import flash_ctl_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       key_wr,
    input  logic [7:0] key_data,
    input  logic       consume,
    output key_state_t state
);

    // Next-state update on key writes and consumption.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= KS_IDLE;
        end else begin
            case (state)
                KS_LOCKED: state <= KS_LOCKED;
                KS_IDLE: begin
                    if (key_wr) state <= (key_data == KEY_CODE_A) ? KS_FIRST : KS_LOCKED;
                end
                KS_FIRST: begin
                    if (key_wr) state <= (key_data == KEY_CODE_B) ? KS_OPEN : KS_LOCKED;
                end
                KS_OPEN: begin
                    if (key_wr)       state <= KS_LOCKED;
                    else if (consume) state <= KS_IDLE;
                end
                default: state <= KS_LOCKED;
            endcase
        end
    end

    // Lock-out must persist until reset.
    assert_lock_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
        state == KS_LOCKED |=> state == KS_LOCKED);

    // An operation may only be requested by the decoder while unlocked.
    assert_consume_when_open_R6: assert property (@(posedge clk) disable iff (!rst_n)
        consume |-> state == KS_OPEN);

    // A completed operation spends the unlock.
    assert_consume_to_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        consume && !key_wr |=> state == KS_IDLE);

endmodule

// File: rtl/flash_busy_timer.sv
// Module: busy timer for flash operations.
// Loads the program or erase duration on a start pulse and counts down;
// busy is high while the count is nonzero.
// Assumes: starts arrive only while not busy and never both at once.
module flash_busy_timer #(
    parameter int PROG_CYC  = 4,
    parameter int ERASE_CYC = 32,
    localparam int MAX_CYC  = (ERASE_CYC > PROG_CYC) ? ERASE_CYC : PROG_CYC,
    localparam int CNT_W    = $clog2(MAX_CYC + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_prog,
    input  logic start_erase,
    output logic busy
);

    logic [CNT_W-1:0] remain;

    // Load the duration on a start, otherwise count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            remain <= '0;
        end else if (start_erase) begin
            remain <= CNT_W'(ERASE_CYC);
        end else if (start_prog) begin
            remain <= CNT_W'(PROG_CYC);
        end else if (remain != '0) begin
            remain <= remain - 1'b1;
        end
    end

    // Busy output is the nonzero count.
    always_comb busy = (remain != '0);

    // Starts come only from an idle controller.
    assert_start_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (start_prog || start_erase) |-> !busy);

    // At most one kind of start per cycle.
    assert_single_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({start_prog, start_erase}));

    // Busy rises right after a start.
    assert_busy_after_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (start_prog || start_erase) |=> busy);

endmodule

// File: rtl/flash_array_model.sv
// Module: behavioural byte-array flash.
// Program ANDs the written byte into the stored one; erase sets every byte of
// the addressed page to all ones in one clock. Storage is not reset, as it
// models non-volatile memory.
// Assumes: PAGE_BYTES and NUM_PAGES are powers of two, NUM_PAGES >= 2.
module flash_array_model
    import flash_ctl_pkg::*;
#(
    parameter int PAGE_BYTES = 1024,
    parameter int NUM_PAGES  = 2,
    localparam int DEPTH     = PAGE_BYTES * NUM_PAGES,
    localparam int PAGE_W    = $clog2(PAGE_BYTES),
    localparam int ADDR_W    = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              prog,
    input  logic              erase,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wdata,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [7:0]        rd_data
);

    logic [7:0] mem [DEPTH];

    // Apply a page erase or a bit-clearing byte program.
    always_ff @(posedge clk) begin
        for (int i = 0; i < DEPTH; i++) begin
            if (erase && ((i / PAGE_BYTES) == int'(addr[ADDR_W-1:PAGE_W]))) begin
                mem[i] <= ERASED_BYTE;
            end else if (prog && (i == int'(addr))) begin
                mem[i] <= mem[i] & wdata;
            end
        end
    end

    // Asynchronous read for observation.
    always_comb rd_data = mem[rd_addr];

    // Program merges with AND.
    assert_prog_and_R4: assert property (@(posedge clk) disable iff (!rst_n)
        prog |=> mem[$past(addr)] == ($past(mem[addr]) & $past(wdata)));

    // Erase leaves the first and last bytes of the page at all ones.
    assert_erase_first_R5: assert property (@(posedge clk) disable iff (!rst_n)
        erase |=> mem[{$past(addr[ADDR_W-1:PAGE_W]), {PAGE_W{1'b0}}}] == ERASED_BYTE);
    assert_erase_last_R5: assert property (@(posedge clk) disable iff (!rst_n)
        erase |=> mem[{$past(addr[ADDR_W-1:PAGE_W]), {PAGE_W{1'b1}}}] == ERASED_BYTE);

endmodule

// File: rtl/flash_prog_ctrl.sv
// Module: key-locked flash program/erase controller (top).
// Holds the enable register, decodes each CPU data write into RAM, byte
// program, page erase or nothing, and stalls the CPU while an operation runs.
// Assumes: the CPU honours busy; the short-address flag is set by the CPU
// for writes issued through its 8-bit address form.
module flash_prog_ctrl
    import flash_ctl_pkg::*;
#(
    parameter int PAGE_BYTES   = 1024,
    parameter int NUM_PAGES    = 2,
    parameter int SHORT_ADDR_W = 8,
    parameter int PROG_CYC     = 4,
    parameter int ERASE_CYC    = 32,
    localparam int ADDR_W      = $clog2(PAGE_BYTES * NUM_PAGES),
    localparam int SHORT_MAX   = (1 << SHORT_ADDR_W) - 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_sel,
    input  logic [7:0]        reg_wdata,
    input  logic              mem_wr,
    input  logic              mem_short,
    input  logic [ADDR_W-1:0] mem_addr,
    input  logic [7:0]        mem_wdata,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [7:0]        rd_data,
    output logic              ram_wr,
    output logic              busy,
    output logic [1:0]        key_state,
    output logic              err_lock,
    output logic              ctrl_wen,
    output logic              ctrl_een
);

    key_state_t ks;
    logic key_wr, ctrl_wr, data_ok, armed, short_block, flash_go, do_prog, do_erase;

    // Decode register and data writes; all are dropped while busy.
    always_comb begin
        key_wr      = reg_wr && !busy && (reg_sel == SEL_KEY);
        ctrl_wr     = reg_wr && !busy && (reg_sel == SEL_CTRL);
        data_ok     = mem_wr && !busy;
        armed       = ctrl_wen && (ks == KS_OPEN);
        short_block = mem_short && (mem_addr > ADDR_W'(SHORT_MAX));
        flash_go    = data_ok && armed && !short_block && !key_wr;
        do_erase    = flash_go && ctrl_een;
        do_prog     = flash_go && !ctrl_een;
        ram_wr      = data_ok && !armed;
    end

    // Enable register: bit 0 program-enable, bit 1 erase-enable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_wen <= 1'b0;
            ctrl_een <= 1'b0;
        end else if (ctrl_wr) begin
            ctrl_wen <= reg_wdata[0];
            ctrl_een <= reg_wdata[1];
        end
    end

    flash_key_fsm u_key (
        .clk      (clk),
        .rst_n    (rst_n),
        .key_wr   (key_wr),
        .key_data (reg_wdata),
        .consume  (flash_go),
        .state    (ks)
    );

    flash_busy_timer #(
        .PROG_CYC  (PROG_CYC),
        .ERASE_CYC (ERASE_CYC)
    ) u_timer (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_prog  (do_prog),
        .start_erase (do_erase),
        .busy        (busy)
    );

    flash_array_model #(
        .PAGE_BYTES (PAGE_BYTES),
        .NUM_PAGES  (NUM_PAGES)
    ) u_array (
        .clk     (clk),
        .rst_n   (rst_n),
        .prog    (do_prog),
        .erase   (do_erase),
        .addr    (mem_addr),
        .wdata   (mem_wdata),
        .rd_addr (rd_addr),
        .rd_data (rd_data)
    );

    // Status outputs.
    always_comb begin
        key_state = ks;
        err_lock  = (ks == KS_LOCKED);
    end

    // A blocked short write keeps the unlock.
    assert_short_keeps_unlock_R8: assert property (@(posedge clk) disable iff (!rst_n)
        data_ok && armed && short_block && !key_wr |=> key_state == 2'd3);

    // Nothing moves the key state while busy.
    assert_busy_key_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(key_state));

    // Nothing moves the enable bits while busy.
    assert_busy_ctrl_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable({ctrl_wen, ctrl_een}));

    // Unlock from idle only via the first code.
    assert_bad_first_key_R3: assert property (@(posedge clk) disable iff (!rst_n)
        key_state == 2'd1 && key_wr && reg_wdata != KEY_CODE_A |=> err_lock);

endmodule

// File: tb/flash_prog_ctrl_tb.sv
`timescale 1ns/1ps
module flash_prog_ctrl_tb;
    localparam int PB = 1024;
    localparam int DEPTH = 2048;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0, reg_sel = 1'b0;
    logic [7:0]  reg_wdata = '0;
    logic        mem_wr = 1'b0, mem_short = 1'b0;
    logic [10:0] mem_addr = '0, rd_addr = '0;
    logic [7:0]  mem_wdata = '0;
    logic [7:0]  rd_data;
    logic        ram_wr, busy, err_lock, ctrl_wen, ctrl_een;
    logic [1:0]  key_state;

    int tests = 0, fails = 0;
    bit done = 0;
    logic [7:0] mirror [DEPTH];

    always #4 clk = ~clk;

    flash_prog_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .mem_wr(mem_wr), .mem_short(mem_short),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .rd_addr(rd_addr),
        .rd_data(rd_data), .ram_wr(ram_wr), .busy(busy), .key_state(key_state),
        .err_lock(err_lock), .ctrl_wen(ctrl_wen), .ctrl_een(ctrl_een)
    );

    function automatic logic [7:0] prog_result(logic [7:0] old, logic [7:0] d);
        return old & d;
    endfunction

    task automatic check(string req, int act, int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic check_byte(string req, logic [10:0] a);
        rd_addr = a;
        #1;
        check(req, rd_data, mirror[a]);
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic reg_write(logic sel, logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_sel = sel; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic unlock();
        reg_write(1'b1, 8'hA5);
        reg_write(1'b1, 8'hF1);
    endtask

    task automatic data_write(logic [10:0] a, logic [7:0] d, logic sh, output logic ram_seen);
        @(negedge clk);
        mem_wr = 1'b1; mem_addr = a; mem_wdata = d; mem_short = sh;
        #1 ram_seen = ram_wr;
        @(negedge clk);
        mem_wr = 1'b0; mem_short = 1'b0;
    endtask

    task automatic busy_len(output int n);
        n = 0;
        while (busy) begin n++; @(negedge clk); end
    endtask

    task automatic erase_mirror(int page);
        for (int j = 0; j < PB; j++) mirror[page*PB + j] = 8'hFF;
    endtask

    initial begin
        #(8 * 190000);
        if (!done) begin
            fails++; tests++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        logic r;
        int n;
        void'($urandom(32'h1234_5678));
        do_reset();
        #1;
        // R1 reset state
        check("R1 key_state", key_state, 1);
        check("R1 busy", busy, 0);
        check("R1 err_lock", err_lock, 0);
        check("R1 enables", {ctrl_een, ctrl_wen}, 0);

        // R2 unlock sequence and R5 erase, R9 erase duration, R6 consume
        reg_write(1'b0, 8'h03);
        reg_write(1'b1, 8'hA5);
        check("R2 first key", key_state, 2);
        reg_write(1'b1, 8'hF1);
        check("R2 second key", key_state, 3);
        data_write(11'h123, 8'h00, 1'b0, r);
        busy_len(n);
        check("R9 erase busy cycles", n, 32);
        check("R6 state after erase", key_state, 1);
        erase_mirror(0);
        unlock();
        data_write(11'h5AB, 8'h00, 1'b0, r);
        busy_len(n);
        erase_mirror(1);
        check_byte("R5 page0 first", 11'h000);
        check_byte("R5 page0 last", 11'h3FF);
        check_byte("R5 page1 first", 11'h400);
        check_byte("R5 page1 last", 11'h7FF);

        // R4 program and R9 program duration
        reg_write(1'b0, 8'h01);
        unlock();
        data_write(11'h010, 8'h3C, 1'b0, r);
        busy_len(n);
        check("R9 program busy cycles", n, 4);
        mirror[11'h010] = prog_result(mirror[11'h010], 8'h3C);
        check_byte("R4 programmed byte", 11'h010);
        check_byte("R4 neighbour low", 11'h00F);
        check_byte("R4 neighbour high", 11'h011);
        unlock();
        data_write(11'h010, 8'hF0, 1'b0, r);
        busy_len(n);
        mirror[11'h010] = prog_result(mirror[11'h010], 8'hF0);
        check_byte("R4 AND merge", 11'h010);

        // R6 no fresh unlock -> RAM
        data_write(11'h010, 8'h00, 1'b0, r);
        check("R6 ram_wr", r, 1);
        check_byte("R6 flash untouched", 11'h010);

        // R7 program-enable clear
        unlock();
        reg_write(1'b0, 8'h00);
        data_write(11'h020, 8'h00, 1'b0, r);
        check("R7 ram_wr", r, 1);
        check("R7 unlock kept", key_state, 3);
        check_byte("R7 flash untouched", 11'h020);
        reg_write(1'b0, 8'h01);
        data_write(11'h020, 8'h55, 1'b0, r);
        busy_len(n);
        mirror[11'h020] = prog_result(mirror[11'h020], 8'h55);
        check_byte("R7 kept unlock programs", 11'h020);

        // R8 short address form
        unlock();
        data_write(11'h1F0, 8'h00, 1'b1, r);
        check("R8 no ram_wr", r, 0);
        check("R8 unlock kept", key_state, 3);
        check("R8 not busy", busy, 0);
        check_byte("R8 flash untouched", 11'h1F0);
        data_write(11'h0F0, 8'h0F, 1'b1, r);
        busy_len(n);
        mirror[11'h0F0] = prog_result(mirror[11'h0F0], 8'h0F);
        check_byte("R8 short in range programs", 11'h0F0);

        // R9 writes during busy ignored
        unlock();
        data_write(11'h030, 8'hAA, 1'b0, r);
        mirror[11'h030] = prog_result(mirror[11'h030], 8'hAA);
        reg_write(1'b1, 8'h13);
        reg_write(1'b0, 8'h03);
        busy_len(n);
        check("R9 key ignored while busy", key_state, 1);
        check("R9 ctrl ignored while busy", {ctrl_een, ctrl_wen}, 1);
        check_byte("R9 program result", 11'h030);

        // Random program/RAM traffic against the mirror (R4, R6)
        for (int k = 0; k < 300; k++) begin
            logic [10:0] a;
            logic [7:0] d;
            a = 11'($urandom_range(0, DEPTH - 1));
            d = 8'($urandom);
            if ($urandom_range(0, 3) != 0) begin
                unlock();
                data_write(a, d, 1'b0, r);
                busy_len(n);
                mirror[a] = prog_result(mirror[a], d);
                check_byte("R4 random program", a);
            end else begin
                data_write(a, d, 1'b0, r);
                check("R6 random ram_wr", r, 1);
                check_byte("R6 random untouched", a);
            end
        end

        // R5 page boundary isolation
        unlock();
        data_write(11'h3FF, 8'h00, 1'b0, r);
        busy_len(n);
        mirror[11'h3FF] = 8'h00;
        reg_write(1'b0, 8'h03);
        unlock();
        data_write(11'h400, 8'h77, 1'b0, r);
        busy_len(n);
        erase_mirror(1);
        check_byte("R5 other page kept", 11'h3FF);
        check_byte("R5 boundary erased", 11'h400);
        check_byte("R5 end erased", 11'h7FF);

        // R3 bad first key, sticky lock
        reg_write(1'b0, 8'h01);
        reg_write(1'b1, 8'hF1);
        check("R3 bad first key", key_state, 0);
        check("R3 err_lock", err_lock, 1);
        unlock();
        check("R3 sticky", key_state, 0);
        data_write(11'h050, 8'h00, 1'b0, r);
        check("R3 ram_wr while locked", r, 1);
        check_byte("R3 flash untouched", 11'h050);
        do_reset();
        #1;
        check("R3 reset clears lock", err_lock, 0);
        // repeated first key
        reg_write(1'b1, 8'hA5);
        reg_write(1'b1, 8'hA5);
        check("R3 wrong order", key_state, 0);
        do_reset();
        // extra key after unlock
        unlock();
        reg_write(1'b1, 8'hA5);
        check("R3 key while open", key_state, 0);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule